// File: doc/BRIEF.md
# External Sync Mode Discriminator and Phase Comparator

This block sits in the timing core of a camera sync generator. It watches two external reference lines: a horizontal line, which may carry HD pulses or composite sync, and a vertical line. From the activity on each line it works out which synchronisation mode applies. It reports that mode as a two-bit code and as two status flags.

Once an external mode is committed, the block compares falling edges. It takes the selected external reference and the matching internal timing signal from the sync generator. Line-lock pairs the vertical signals. V-reset with H-PLL pairs the horizontal signals. The block outputs the edge order as a three-state phase-detector signal for an off-chip loop filter. The value pin and its enable are kept separate so that the pad ring can build the actual three-state driver.

All inputs are sampled on the master clock. Separating sync from a composite input is done upstream and is not part of this block.

Top module: `extsync_mode_pd`

## Requirements
- R1: With no falling edges on either external input, the mode code is 0 (internal), and `hv_det_o` and `ext_o` are both low.
- R2: With falling edges only on `ext_hd_i`, the mode code stays 0 and both flags stay low.
- R3: With falling edges only on `ext_vd_i`, the mode code becomes 1 (line-lock), and `hv_det_o` and `ext_o` are both high.
- R4: With falling edges on both external inputs, the mode code becomes 2 (V-reset + H-PLL), with `hv_det_o` low and `ext_o` high. Code 3 never appears.
- R5: An input counts as active only after two falling edges arrive less than its window apart. The window is HD_WIN_LINES lines for the horizontal input and VD_WIN_FIELDS fields for the vertical input. An input becomes inactive once a full window passes with no edge.
- R6: The committed mode changes only on a qualification tick, which comes every vertical window. A new activity state must be sampled on two consecutive ticks before it takes effect. So a change never takes effect sooner than one window after the activity changes, and always within two windows plus a few cycles.
- R7: In line-lock mode the comparator pairs `ext_vd_i` with `int_vd_i`. When the external falling edge comes first, `comp_oe_o` is high and `comp_o` is high. This lasts exactly as many clocks as the edges are apart. Horizontal edges have no effect.
- R8: When the internal falling edge comes first, `comp_oe_o` is high and `comp_o` is low for exactly the gap in clocks.
- R9: In V-reset + H-PLL mode the comparator pairs `ext_hd_i` with `int_hd_i`. Vertical edge offsets produce no pulse.
- R10: `comp_oe_o` is low (high impedance) in internal mode, between pulses, and when both compared edges fall on the same clock.
- R11: After reset the mode code is 0, both flags are low and `comp_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_hd_i | input | 1 | External horizontal reference or composite sync |
| ext_vd_i | input | 1 | External vertical reference |
| int_hd_i | input | 1 | Internal horizontal drive from the sync generator |
| int_vd_i | input | 1 | Internal vertical drive from the sync generator |
| hv_det_o | output | 1 | High in line-lock, low otherwise |
| ext_o | output | 1 | High whenever an external mode is committed |
| mode_o | output | 2 | 0 internal, 1 line-lock, 2 V-reset + H-PLL |
| comp_o | output | 1 | Phase-detector level, valid while enabled |
| comp_oe_o | output | 1 | Phase-detector drive enable (low means high impedance) |

## Verification
Some properties are checked on every cycle:
- The committed mode moves only on a qualification tick.
- The flags never show vertical-PLL without external.
- No illegal mode code appears.
- The comparator is never enabled in internal mode.
- Every high pulse starts right after a reference edge, and every low pulse right after an internal edge.
- The vertical input becomes active only on an edge.

Other behaviour can only be shown by the bench's scenarios:
- The mode each activity pattern produces.
- The hysteresis window after an activity change.
- Timeout of a sparse or stopped input.
- Which signal pair is compared in each mode.
- The exact pulse widths.

// File: rtl/extsync_pkg.sv
package extsync_pkg;

  typedef enum logic [1:0] {
    SM_INTERNAL    = 2'd0,
    SM_LINELOCK    = 2'd1,
    SM_VRESET_HPLL = 2'd2
  } sync_mode_e;

  typedef enum logic [1:0] {
    PD_IDLE     = 2'd0,
    PD_REF_LEAD = 2'd1,
    PD_INT_LEAD = 2'd2
  } pd_state_e;

  // One-clock falling-edge pulse from two successive samples.
  function automatic logic fall_of(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // Mode implied by the current activity of the two external lines.
  function automatic sync_mode_e classify(input logic hd_act, input logic vd_act);
    if (vd_act && hd_act) return SM_VRESET_HPLL;
    else if (vd_act)      return SM_LINELOCK;
    else                  return SM_INTERNAL;
  endfunction

  // Status flags {hv_det, ext} for a committed mode.
  function automatic logic [1:0] flags_of(input sync_mode_e m);
    case (m)
      SM_LINELOCK:    return 2'b11;
      SM_VRESET_HPLL: return 2'b01;
      default:        return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/fall_detect.sv
module fall_detect
  import extsync_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] fall_o
);

  logic [N-1:0] cur_q;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '1;
      prev_q <= '1;
    end else begin
      cur_q  <= sig_i;
      prev_q <= cur_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign fall_o[i] = fall_of(prev_q[i], cur_q[i]);
  end

endmodule

// File: rtl/activity_monitor.sv
module activity_monitor #(
  parameter int WIN_CLKS = 3640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  output logic active_o
);

  localparam int TW = $clog2(WIN_CLKS + 1);
  localparam logic [TW-1:0] LAST = TW'(WIN_CLKS - 1);

  logic [TW-1:0] age_q;
  logic          seen_q;
  logic          act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      seen_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (fall_i) begin
      age_q  <= '0;
      seen_q <= 1'b1;
      act_q  <= seen_q;
    end else if (seen_q) begin
      if (age_q == LAST) begin
        age_q  <= '0;
        seen_q <= 1'b0;
        act_q  <= 1'b0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/mode_qualifier.sv
module mode_qualifier
  import extsync_pkg::*;
#(
  parameter int QUAL_CLKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sync_mode_e cand_i,
  output sync_mode_e mode_o,
  output logic       tick_o
);

  localparam int CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);

  logic [CW-1:0] cnt_q;
  sync_mode_e    samp_q;
  sync_mode_e    mode_q;
  logic          tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      samp_q <= SM_INTERNAL;
      mode_q <= SM_INTERNAL;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick) begin
        samp_q <= cand_i;
        if (cand_i == samp_q) mode_q <= cand_i;
      end
    end
  end

  assign mode_o = mode_q;
  assign tick_o = tick;

endmodule

// File: rtl/phase_detect.sv
module phase_detect
  import extsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ref_fall_i,
  input  logic int_fall_i,
  output logic comp_o,
  output logic oe_o
);

  pd_state_e st_q;
  pd_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = PD_IDLE;
    end else begin
      case (st_q)
        PD_IDLE: begin
          if (ref_fall_i && !int_fall_i)      st_d = PD_REF_LEAD;
          else if (int_fall_i && !ref_fall_i) st_d = PD_INT_LEAD;
        end
        PD_REF_LEAD: if (int_fall_i) st_d = PD_IDLE;
        PD_INT_LEAD: if (ref_fall_i) st_d = PD_IDLE;
        default:     st_d = PD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PD_IDLE;
    else        st_q <= st_d;
  end

  assign oe_o   = en_i && (st_q != PD_IDLE);
  assign comp_o = oe_o && (st_q == PD_REF_LEAD);

endmodule

// File: rtl/extsync_mode_pd.sv
module extsync_mode_pd
  import extsync_pkg::*;
#(
  parameter int LINE_CLKS     = 910,
  parameter int FIELD_LINES   = 263,
  parameter int HD_WIN_LINES  = 4,
  parameter int VD_WIN_FIELDS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_hd_i,
  input  logic       ext_vd_i,
  input  logic       int_hd_i,
  input  logic       int_vd_i,
  output logic       hv_det_o,
  output logic       ext_o,
  output logic [1:0] mode_o,
  output logic       comp_o,
  output logic       comp_oe_o
);

  localparam int HD_WIN_CLKS = HD_WIN_LINES * LINE_CLKS;
  localparam int VD_WIN_CLKS = VD_WIN_FIELDS * FIELD_LINES * LINE_CLKS;
  localparam int QUAL_CLKS   = VD_WIN_CLKS;

  // Bit order of the sampled input bundle.
  localparam int B_EHD = 0;
  localparam int B_EVD = 1;
  localparam int B_IHD = 2;
  localparam int B_IVD = 3;

  logic [3:0] raw;
  logic [3:0] falls;
  logic       ehd_fall, evd_fall, ihd_fall, ivd_fall;
  logic       hd_act, vd_act;
  sync_mode_e cand;
  sync_mode_e mode_q;
  logic       qual_tick;
  logic       ref_fall, int_fall;
  logic       cmp_en;

  assign raw = {int_vd_i, int_hd_i, ext_vd_i, ext_hd_i};

  fall_detect #(.N(4)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (raw),
    .fall_o (falls)
  );

  assign ehd_fall = falls[B_EHD];
  assign evd_fall = falls[B_EVD];
  assign ihd_fall = falls[B_IHD];
  assign ivd_fall = falls[B_IVD];

  activity_monitor #(.WIN_CLKS(HD_WIN_CLKS)) u_hd_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_i   (ehd_fall),
    .active_o (hd_act)
  );

  activity_monitor #(.WIN_CLKS(VD_WIN_CLKS)) u_vd_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_i   (evd_fall),
    .active_o (vd_act)
  );

  assign cand = classify(hd_act, vd_act);

  mode_qualifier #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .cand_i (cand),
    .mode_o (mode_q),
    .tick_o (qual_tick)
  );

  always_comb begin
    cmp_en   = 1'b0;
    ref_fall = 1'b0;
    int_fall = 1'b0;
    case (mode_q)
      SM_LINELOCK: begin
        cmp_en   = 1'b1;
        ref_fall = evd_fall;
        int_fall = ivd_fall;
      end
      SM_VRESET_HPLL: begin
        cmp_en   = 1'b1;
        ref_fall = ehd_fall;
        int_fall = ihd_fall;
      end
      default: ;
    endcase
  end

  phase_detect u_pd (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (cmp_en),
    .ref_fall_i (ref_fall),
    .int_fall_i (int_fall),
    .comp_o     (comp_o),
    .oe_o       (comp_oe_o)
  );

  assign mode_o              = mode_q;
  assign {hv_det_o, ext_o}   = flags_of(mode_q);

endmodule

// File: rtl/extsync_mode_pd_chk.sv
module extsync_mode_pd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       hv_det_o,
  input logic       ext_o,
  input logic       comp_o,
  input logic       comp_oe_o,
  input logic       qual_tick,
  input logic       ref_fall,
  input logic       int_fall,
  input logic       evd_fall,
  input logic       vd_act
);

  // R6: the committed mode only moves on a qualification tick
  a_r6_mode_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_tick |=> $stable(mode_o));

  // R4: code 3 is never produced
  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);

  // R3: vertical-PLL flag never without the external flag
  a_r3_flag_pair: assert property (@(posedge clk) disable iff (!rst_n)
    hv_det_o |-> ext_o);

  // R10: no drive while internal sync is committed
  a_r10_quiet_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> !comp_oe_o);

  // R7: a high pulse opens right after a reference edge
  a_r7_high_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(comp_oe_o) && comp_o) |-> $past(ref_fall));

  // R8: a low pulse opens right after an internal edge
  a_r8_low_after_int: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(comp_oe_o) && !comp_o) |-> $past(int_fall));

  // R5: vertical activity only begins on an edge
  a_r5_act_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vd_act) |-> $past(evd_fall));

endmodule

bind extsync_mode_pd extsync_mode_pd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_o    (mode_o),
  .hv_det_o  (hv_det_o),
  .ext_o     (ext_o),
  .comp_o    (comp_o),
  .comp_oe_o (comp_oe_o),
  .qual_tick (qual_tick),
  .ref_fall  (ref_fall),
  .int_fall  (int_fall),
  .evd_fall  (evd_fall),
  .vd_act    (vd_act)
);

// File: tb/sim_extsync_mode_pd.sv
`timescale 1ns/1ps
module sim_extsync_mode_pd;

  localparam int LINE   = 40;
  localparam int FLINES = 8;
  localparam int FIELD  = LINE * FLINES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_hd = 1'b1, ext_vd = 1'b1, int_hd = 1'b1, int_vd = 1'b1;
  logic hv, ext, comp, oe;
  logic [1:0] mode;

  always #2.5 clk = ~clk;

  extsync_mode_pd #(
    .LINE_CLKS(LINE), .FIELD_LINES(FLINES), .HD_WIN_LINES(4), .VD_WIN_FIELDS(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ext_hd_i(ext_hd), .ext_vd_i(ext_vd),
    .int_hd_i(int_hd), .int_vd_i(int_vd), .hv_det_o(hv), .ext_o(ext),
    .mode_o(mode), .comp_o(comp), .comp_oe_o(oe)
  );

  typedef struct {
    bit    lvl;
    int    width;
    string tag;
  } pulse_t;

  pulse_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected mode code and flags from R1..R4.
  task automatic check_mode(input int m, input string tag);
    int ehv, eext;
    ehv  = (m == 1) ? 1 : 0;
    eext = (m != 0) ? 1 : 0;
    check(mode == m[1:0], tag, "mode", mode, m);
    check(hv == ehv[0],   tag, "hv_det", hv, ehv);
    check(ext == eext[0], tag, "ext", ext, eext);
  endtask

  // Drive one period: external lines fall at e_at, internal at their own offsets.
  task automatic span(input int len, input bit ehd, input bit evd, input bit ihd,
                      input bit ivd, input int e_at, input int ihd_at, input int ivd_at);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      ext_hd = !(ehd && c >= e_at   && c < e_at + 12);
      ext_vd = !(evd && c >= e_at   && c < e_at + 12);
      int_hd = !(ihd && c >= ihd_at && c < ihd_at + 12);
      int_vd = !(ivd && c >= ivd_at && c < ivd_at + 12);
    end
  endtask

  task automatic push(input bit lvl, input int w, input string tag);
    pulse_t p;
    p.lvl = lvl; p.width = w; p.tag = tag;
    exp_q.push_back(p);
  endtask

  // Line-lock field; gap>0 external leads, gap<0 internal leads.
  task automatic ll_frame(input int gap, input bit hd_noise);
    int e, i;
    e = (gap < 0) ? -gap : 0;
    i = (gap > 0) ? gap : 0;
    if (gap > 0) push(1'b1, gap, "R7");
    if (gap < 0) push(1'b0, -gap, "R8");
    span(FIELD, 1'b0, 1'b1, hd_noise, 1'b1, e, 6, i);
  endtask

  // V-reset + H-PLL field of FLINES lines; vertical edges only on line 0.
  task automatic hv_frame(input int gap, input int vd_off);
    int e, i;
    e = (gap < 0) ? -gap : 0;
    i = (gap > 0) ? gap : 0;
    for (int l = 0; l < FLINES; l++) begin
      if (gap > 0) push(1'b1, gap, "R9");
      if (gap < 0) push(1'b0, -gap, "R9");
      span(LINE, 1'b1, (l == 0), 1'b1, (l == 0), e, i, e + vd_off);
    end
  endtask

  // Monitor: measures each enabled pulse and compares it with the queue.
  bit in_pulse = 0;
  bit p_lvl = 0;
  int p_w = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (oe) begin
        if (!in_pulse) begin
          in_pulse = 1; p_lvl = comp; p_w = 1;
        end else begin
          p_w++;
        end
      end else if (in_pulse) begin
        in_pulse = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected pulse width", p_w, 0);
        end else begin
          pulse_t p;
          p = exp_q.pop_front();
          check(p_lvl == p.lvl, p.tag, "pulse level", p_lvl, p.lvl);
          check(p_w == p.width, p.tag, "pulse width", p_w, p.width);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check_mode(0, "R11");
    check(oe == 1'b0, "R11", "comp_oe", oe, 0);

    // R1: quiet inputs
    span(2000, 0, 0, 0, 0, 0, 0, 0);
    check_mode(0, "R1");

    // R2 / R10: horizontal activity only, internal edges offset but no drive
    for (int k = 0; k < 40; k++) span(LINE, 1, 0, 1, 0, 0, 5, 0);
    check_mode(0, "R2");

    // R6: vertical activity appears; not committed within one window
    span(FIELD, 0, 1, 0, 1, 0, 0, 0);
    span(FIELD, 0, 1, 0, 1, 0, 0, 0);
    span(300,   0, 1, 0, 1, 0, 0, 0);
    check_mode(0, "R6");
    for (int k = 0; k < 6; k++) span(FIELD, 0, 1, 0, 1, 0, 0, 0);
    check_mode(1, "R3");

    // R7/R8: line-lock comparisons; R7: horizontal edges ignored; R10 coincident
    ll_frame(3, 1'b0);
    ll_frame(7, 1'b0);
    ll_frame(-4, 1'b0);
    ll_frame(-9, 1'b0);
    ll_frame(0, 1'b1);
    ll_frame(0, 1'b0);
    check(exp_q.size() == 0, "R7", "pending pulses", exp_q.size(), 0);

    // R4: both inputs active
    for (int k = 0; k < 6; k++) hv_frame(0, 0);
    check_mode(2, "R4");

    // R9: horizontal pair compared, vertical offsets ignored
    hv_frame(5, 0);
    hv_frame(-3, 0);
    hv_frame(0, 6);
    check(exp_q.size() == 0, "R9", "pending pulses", exp_q.size(), 0);

    // R5: everything stops -> timeout back to internal
    span(3000, 0, 0, 0, 0, 0, 0, 0);
    check_mode(0, "R5");
    // R5: a single vertical edge is not activity
    span(2000, 0, 1, 0, 0, 0, 0, 0);
    check_mode(0, "R5");
    // R5: edges spaced wider than the window are not activity
    for (int k = 0; k < 5; k++) span(700, 0, 1, 0, 0, 0, 0, 0);
    check_mode(0, "R5");
    check(oe == 1'b0, "R10", "comp_oe idle", oe, 0);
    check(exp_q.size() == 0, "R10", "pending pulses", exp_q.size(), 0);

    finish_run();
  end

endmodule